// File: doc/BRIEF.md
# UART Register Block with Interrupt Combining

This block is the processor-facing register set of a simple serial port. It sits on a word-addressed, 32-bit, APB-style read/write port and decodes a small map. The map holds a data register, a status-flag register and baud divisor storage (low-power, integer and fractional). It also holds line-control, control, FIFO-level and DMA-control storage, and an interrupt set made of mask, raw status, masked status and write-one-to-clear registers. A fixed window at the top of a 4 KB space returns eight identification bytes, one per word.

A write to the data register hands the low byte to a transmitter stub with a one-cycle strobe, and it raises the transmit raw interrupt. A read of the data register returns the byte offered by an external receive buffer and pulses a pop request toward it. The receive buffer raises the receive raw interrupt with a one-cycle pulse. It also supplies four live status bits, which the block registers into the flag register. One level interrupt output is high while any raw bit is also enabled in the mask.

The register index is the byte offset divided by four: data 0, flags 6, low-power divisor 8, integer divisor 9, fractional divisor 10, line control 11, control 12, FIFO level 13, mask 14, raw status 15, masked status 16, clear 17, DMA control 18.

Top module: `uart_regblock`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x300, the FIFO-level register 0x12 and the flag register 0x90. Every other register reads 0. The flag register reads 0x90 for as long as reset is held.
- R2: The registers at indices 8, 9, 10, 11, 12, 13 and 18 store all 32 written bits and read them back. A value written to DMA control, including non-zero low two bits, is stored and has no other effect.
- R3: Reads of byte offsets 0xFE0, 0xFE4, ... 0xFFC return, in that order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in the low byte, with the upper bits zero.
- R4: A write to the data register drives tx_byte with pwdata[7:0] and holds tx_strobe high for exactly the one cycle after the write edge. A read of the data register returns rx_data zero-extended and drives rx_pop high during that access phase only.
- R5: Raw status bit 5 (transmit) is set by every data-register write, and bit 4 (receive) is set by an rx_set pulse. All other raw bits read 0. A set arriving in the same cycle as a clear of the same bit wins.
- R6: Writing the clear register (index 17) clears each raw bit whose written bit is 1 and leaves the other raw bits unchanged. The clear register reads 0.
- R7: The mask register stores 32 bits, and the masked-status register reads raw status AND mask.
- R8: irq is high exactly when raw status AND mask is non-zero. It follows any set, clear or mask write from the clock edge that commits that change.
- R9: Flag register bits 7..4 show stat_in[3..0] as sampled at the previous clock edge. The bits are transmit-empty 0x80, receive-full 0x40, transmit-full 0x20 and receive-empty 0x10, and all other bits read 0.
- R10: Reads of undefined offsets return 0, and writes to them change nothing. Writes to the flag, raw-status and masked-status registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Select for this block |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset inside the 4 KB space |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| rx_data | input | 8 | Byte presented by the receive buffer |
| rx_pop | output | 1 | High while the data register is being read |
| rx_set | input | 1 | One-cycle pulse that sets the receive raw interrupt |
| stat_in | input | 4 | Live status {tx empty, rx full, tx full, rx empty} |
| tx_byte | output | 8 | Byte toward the transmitter stub |
| tx_strobe | output | 1 | One-cycle strobe qualifying tx_byte |
| irq | output | 1 | Combined level interrupt |

## Verification
If the raw-status or mask state goes wrong, irq is wrong from the very next clock edge. The masked-status read then disagrees with the raw status and mask read separately. A wrong decode would either overwrite a neighbouring configuration register, which shows up the next time that register is read back, or fail to return an identification byte. Flag or strobe faults show within one cycle at stat_in-driven reads or at tx_strobe. The same-cycle set-and-clear case and write-one-to-clear with stray bits are driven on purpose, because they hide when events are kept apart.

// File: rtl/uart_reg_pkg.sv
// Package uart_reg_pkg
// Shared constants of the UART register block: register indices, interrupt
// bit positions, reset values and the identification byte sequence.
// Assumes a 32-bit data path; indices are word offsets (byte offset >> 2).
package uart_reg_pkg;

    localparam int IDX_DATA  = 0;
    localparam int IDX_FLAG  = 6;
    localparam int IDX_LPDIV = 8;
    localparam int IDX_IDIV  = 9;
    localparam int IDX_FDIV  = 10;
    localparam int IDX_LINE  = 11;
    localparam int IDX_CTRL  = 12;
    localparam int IDX_LVL   = 13;
    localparam int IDX_MASK  = 14;
    localparam int IDX_RAW   = 15;
    localparam int IDX_MSK   = 16;
    localparam int IDX_CLR   = 17;
    localparam int IDX_DMA   = 18;
    localparam int NUM_IDX   = 19;

    // plain stored configuration registers
    localparam int NUM_CFG   = 7;

    localparam int BIT_TX    = 5;
    localparam int BIT_RX    = 4;

    localparam logic [3:0] FLAG_RST = 4'b1001;   // tx empty, rx empty

    // register index held by configuration slot i
    function automatic int cfg_index(input int i);
        case (i)
            0:       return IDX_LPDIV;
            1:       return IDX_IDIV;
            2:       return IDX_FDIV;
            3:       return IDX_LINE;
            4:       return IDX_CTRL;
            5:       return IDX_LVL;
            default: return IDX_DMA;
        endcase
    endfunction

    // reset value of configuration slot i
    function automatic logic [31:0] cfg_reset(input int i);
        case (i)
            4:       return 32'h0000_0300;
            5:       return 32'h0000_0012;
            default: return 32'h0;
        endcase
    endfunction

    // identification byte k of the top window
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_reg_decode.sv
// Module uart_reg_decode
// Turns the word address and transfer controls into per-index write enables,
// a legal-index flag, the identification-window hit and the data-read pop.
// Assumes the word address is the byte offset with its two low bits dropped.
module uart_reg_decode
    import uart_reg_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [IDX_W-1:0]   word_addr,
    output logic [NUM_IDX-1:0] wr_en,
    output logic               idx_ok,
    output logic               id_hit,
    output logic [2:0]         id_sel,
    output logic               data_pop
);

    logic acc_wr;
    logic acc_rd;

    // qualify the access phase of a transfer
    always_comb begin
        acc_wr = psel && penable && pwrite;
        acc_rd = psel && penable && !pwrite;
    end

    // classify the address
    always_comb begin
        idx_ok   = (word_addr < IDX_W'(NUM_IDX));
        id_hit   = &word_addr[IDX_W-1:3];
        id_sel   = word_addr[2:0];
        data_pop = acc_rd && (word_addr == IDX_W'(IDX_DATA));
    end

    // one write enable per register index
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_wen
        assign wr_en[g] = acc_wr && (word_addr == IDX_W'(g));
    end

endmodule

// File: rtl/uart_reg_irq.sv
// Module uart_reg_irq
// Holds the transmit and receive raw interrupt bits and the mask, and
// combines them into one level interrupt. Sets win over a same-cycle clear.
// Assumes set inputs are single-cycle pulses from the owning logic.
module uart_reg_irq
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_set,
    input  logic              rx_set,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq
);

    logic [1:0]        raw_q;     // [1] transmit, [0] receive
    logic [1:0]        clr_bits;
    logic [DATA_W-1:0] mask_q;

    // bits removed by a clear write
    always_comb begin
        clr_bits = clr_we ? {wdata[BIT_TX], wdata[BIT_RX]} : 2'b00;
    end

    // raw status update, sets applied after clears
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 2'b00;
        else        raw_q <= (raw_q & ~clr_bits) | {tx_set, rx_set};
    end

    // interrupt mask storage
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // place raw bits at their register positions and combine
    always_comb begin
        raw_o         = '0;
        raw_o[BIT_TX] = raw_q[1];
        raw_o[BIT_RX] = raw_q[0];
        mask_o        = mask_q;
        irq           = |(raw_o & mask_q);
    end

    p_txset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> raw_q[1]);

    p_setwins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> raw_q[0]);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata[BIT_RX] && !rx_set) |=> !raw_q[0]);

    p_irqrise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tx_set || rx_set || mask_we));

endmodule

// File: rtl/uart_reg_rdmux.sv
// Module uart_reg_rdmux
// Selects read data for the current address: identification window,
// configuration storage, live registers, or zero for anything else.
// Assumes a purely combinational read, valid during the access phase.
module uart_reg_rdmux
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic [IDX_W-1:0]                word_addr,
    input  logic                            idx_ok,
    input  logic                            id_hit,
    input  logic [2:0]                      id_sel,
    input  logic [7:0]                      rx_data,
    input  logic [3:0]                      flags,
    input  logic [NUM_CFG-1:0][DATA_W-1:0]  cfg,
    input  logic [DATA_W-1:0]               raw,
    input  logic [DATA_W-1:0]               mask,
    output logic [DATA_W-1:0]               rdata
);

    // read data selection
    always_comb begin
        rdata = '0;
        if (id_hit) begin
            rdata[7:0] = id_byte(id_sel);
        end else if (idx_ok) begin
            case (int'(word_addr))
                IDX_DATA: rdata[7:0] = rx_data;
                IDX_FLAG: rdata[7:4] = flags;
                IDX_MASK: rdata      = mask;
                IDX_RAW:  rdata      = raw;
                IDX_MSK:  rdata      = raw & mask;
                default:  rdata      = '0;
            endcase
            for (int i = 0; i < NUM_CFG; i++) begin
                if (int'(word_addr) == cfg_index(i)) rdata = cfg[i];
            end
        end
    end

endmodule

// File: rtl/uart_regblock.sv
// Module uart_regblock
// Bus-facing register block of a simple UART: configuration storage, status
// flags, transmit byte hand-off, receive byte pass-through and interrupts.
// Assumes an APB-style two-phase transfer, synchronous active-low reset,
// and an external receive buffer that supplies rx_data, rx_set and stat_in.
module uart_regblock
    import uart_reg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    input  logic              rx_set,
    input  logic [3:0]        stat_in,
    output logic [7:0]        tx_byte,
    output logic              tx_strobe,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]               word_addr;
    logic [NUM_IDX-1:0]             wr_en;
    logic                           idx_ok;
    logic                           id_hit;
    logic [2:0]                     id_sel;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [3:0]                     flags_q;
    logic [DATA_W-1:0]              raw;
    logic [DATA_W-1:0]              mask;
    logic                           unused_addr_bits;

    assign word_addr        = paddr[ADDR_W-1:2];
    assign unused_addr_bits = &{1'b0, paddr[1:0]};

    uart_reg_decode #(.IDX_W(IDX_W)) u_dec (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .word_addr (word_addr),
        .wr_en     (wr_en),
        .idx_ok    (idx_ok),
        .id_hit    (id_hit),
        .id_sel    (id_sel),
        .data_pop  (rx_pop)
    );

    // one stored configuration register per slot
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        localparam int RIDX = cfg_index(i);
        // load on a write to this slot's index
        always_ff @(posedge clk) begin
            if (!rst_n)           cfg_q[i] <= DATA_W'(cfg_reset(i));
            else if (wr_en[RIDX]) cfg_q[i] <= pwdata;
        end
    end

    // sample the live status bits of the receive and transmit side
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAG_RST;
        else        flags_q <= stat_in;
    end

    // hand the written byte to the transmitter stub
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= 8'h00;
        end else begin
            tx_strobe <= wr_en[IDX_DATA];
            if (wr_en[IDX_DATA]) tx_byte <= pwdata[7:0];
        end
    end

    uart_reg_irq #(.DATA_W(DATA_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_set  (wr_en[IDX_DATA]),
        .rx_set  (rx_set),
        .clr_we  (wr_en[IDX_CLR]),
        .mask_we (wr_en[IDX_MASK]),
        .wdata   (pwdata),
        .raw_o   (raw),
        .mask_o  (mask),
        .irq     (irq)
    );

    uart_reg_rdmux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
        .word_addr (word_addr),
        .idx_ok    (idx_ok),
        .id_hit    (id_hit),
        .id_sel    (id_sel),
        .rx_data   (rx_data),
        .flags     (flags_q),
        .cfg       (cfg_q),
        .raw       (raw),
        .mask      (mask),
        .rdata     (prdata)
    );

    p_txout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && word_addr == IDX_W'(IDX_DATA))
        |=> (tx_strobe && tx_byte == $past(pwdata[7:0])));

    p_txpulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite && word_addr == IDX_W'(IDX_DATA)) |=> !tx_strobe);

    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (flags_q == $past(stat_in)));

    p_cfgkeep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(cfg_q));

endmodule

// File: tb/sim_uart_regblock.sv
// Bench for uart_regblock: a vector table of register reads and writes,
// then directed tests for reset, data hand-off, interrupts and flags.
module sim_uart_regblock;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 43;
    localparam int WD_CYCLES  = 20000;

    // {write, req[3:0], addr[11:0], data[31:0], expected[31:0]}
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 4'd1,  12'h030, 32'h0, 32'h0000_0300},   // R1 control
        {1'b0, 4'd1,  12'h034, 32'h0, 32'h0000_0012},   // R1 fifo level
        {1'b0, 4'd9,  12'h018, 32'h0, 32'h0000_0090},   // R9 flags
        {1'b0, 4'd1,  12'h020, 32'h0, 32'h0},           // R1
        {1'b0, 4'd1,  12'h038, 32'h0, 32'h0},           // R1 mask
        {1'b0, 4'd1,  12'h03C, 32'h0, 32'h0},           // R1 raw
        {1'b0, 4'd1,  12'h048, 32'h0, 32'h0},           // R1 dma
        {1'b1, 4'd2,  12'h020, 32'h0000_00A5, 32'h0},   // R2
        {1'b0, 4'd2,  12'h020, 32'h0, 32'h0000_00A5},
        {1'b1, 4'd2,  12'h024, 32'h1234_5678, 32'h0},
        {1'b0, 4'd2,  12'h024, 32'h0, 32'h1234_5678},
        {1'b1, 4'd2,  12'h028, 32'h0000_003F, 32'h0},
        {1'b0, 4'd2,  12'h028, 32'h0, 32'h0000_003F},
        {1'b1, 4'd2,  12'h02C, 32'h0000_0070, 32'h0},
        {1'b0, 4'd2,  12'h02C, 32'h0, 32'h0000_0070},
        {1'b1, 4'd2,  12'h030, 32'h0000_0301, 32'h0},
        {1'b0, 4'd2,  12'h030, 32'h0, 32'h0000_0301},
        {1'b1, 4'd2,  12'h034, 32'h0000_0024, 32'h0},
        {1'b0, 4'd2,  12'h034, 32'h0, 32'h0000_0024},
        {1'b1, 4'd2,  12'h048, 32'h0000_0003, 32'h0},   // R2 dma low bits
        {1'b0, 4'd2,  12'h048, 32'h0, 32'h0000_0003},
        {1'b0, 4'd3,  12'hFE0, 32'h0, 32'h0000_0011},   // R3 id window
        {1'b0, 4'd3,  12'hFE4, 32'h0, 32'h0000_0010},
        {1'b0, 4'd3,  12'hFE8, 32'h0, 32'h0000_0014},
        {1'b0, 4'd3,  12'hFEC, 32'h0, 32'h0000_0000},
        {1'b0, 4'd3,  12'hFF0, 32'h0, 32'h0000_000D},
        {1'b0, 4'd3,  12'hFF4, 32'h0, 32'h0000_00F0},
        {1'b0, 4'd3,  12'hFF8, 32'h0, 32'h0000_0005},
        {1'b0, 4'd3,  12'hFFC, 32'h0, 32'h0000_00B1},
        {1'b1, 4'd10, 12'h018, 32'h0000_FFFF, 32'h0},   // R10 read-only
        {1'b0, 4'd10, 12'h018, 32'h0, 32'h0000_0090},
        {1'b1, 4'd10, 12'h03C, 32'h0000_FFFF, 32'h0},
        {1'b0, 4'd10, 12'h03C, 32'h0, 32'h0},
        {1'b1, 4'd10, 12'h040, 32'h0000_FFFF, 32'h0},
        {1'b0, 4'd10, 12'h040, 32'h0, 32'h0},
        {1'b0, 4'd6,  12'h044, 32'h0, 32'h0},           // R6 clear reads 0
        {1'b1, 4'd10, 12'h004, 32'h0000_00FF, 32'h0},   // R10 undefined
        {1'b0, 4'd10, 12'h004, 32'h0, 32'h0},
        {1'b1, 4'd10, 12'h04C, 32'h0000_00FF, 32'h0},
        {1'b0, 4'd10, 12'h04C, 32'h0, 32'h0},
        {1'b0, 4'd10, 12'h100, 32'h0, 32'h0},
        {1'b0, 4'd10, 12'h020, 32'h0, 32'h0000_00A5},
        {1'b0, 4'd10, 12'h038, 32'h0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_pop;
    logic        rx_set = 1'b0;
    logic [3:0]  stat_in = 4'b0000;
    logic [7:0]  tx_byte;
    logic        tx_strobe;
    logic        irq;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic        done    = 1'b0;
    logic        pop_seen;
    logic [31:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_regblock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .rx_data   (rx_data),
        .rx_pop    (rx_pop),
        .rx_set    (rx_set),
        .stat_in   (stat_in),
        .tx_byte   (tx_byte),
        .tx_strobe (tx_strobe),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        pop_seen = rx_pop;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] v,
                          input logic with_rx);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v;
        @(negedge clk);
        penable = 1'b1;
        rx_set  = with_rx;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_set = 1'b0;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=finished", WD_CYCLES);
            finish_run();
        end
    end

    initial begin
        // R1: reset state, flags hold 0x90 while reset is low
        repeat (3) @(negedge clk);
        apb_rd(12'h018, rd);
        chk("R1", "flags in reset", rd, 32'h90);
        chk("R1", "irq in reset", {31'b0, irq}, 32'h0);
        chk("R1", "tx_strobe in reset", {31'b0, tx_strobe}, 32'h0);
        @(negedge clk);
        rst_n   = 1'b1;
        stat_in = 4'b1001;
        @(negedge clk);

        // vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][80]) begin
                apb_wr(VEC[k][75:64], VEC[k][63:32], 1'b0);
            end else begin
                apb_rd(VEC[k][75:64], rd);
                chk($sformatf("R%0d", VEC[k][79:76]),
                    $sformatf("vector %0d addr %h", k, VEC[k][75:64]),
                    rd, VEC[k][31:0]);
            end
        end

        // R4: data write hands off the low byte for one cycle
        apb_wr(12'h000, 32'h0000_01C3, 1'b0);
        chk("R4", "tx_strobe after write", {31'b0, tx_strobe}, 32'h1);
        chk("R4", "tx_byte", {24'b0, tx_byte}, 32'hC3);
        @(negedge clk);
        chk("R4", "tx_strobe one cycle", {31'b0, tx_strobe}, 32'h0);

        // R5: transmit raw bit set, R8: masked off so no irq
        apb_rd(12'h03C, rd);
        chk("R5", "raw after data write", rd, 32'h20);
        chk("R8", "irq masked", {31'b0, irq}, 32'h0);

        // R7 / R8: enable transmit interrupt
        apb_wr(12'h038, 32'h0000_0020, 1'b0);
        chk("R8", "irq after mask", {31'b0, irq}, 32'h1);
        apb_rd(12'h040, rd);
        chk("R7", "masked status", rd, 32'h20);

        // R6: clear transmit bit
        apb_wr(12'h044, 32'h0000_0020, 1'b0);
        chk("R8", "irq after clear", {31'b0, irq}, 32'h0);
        apb_rd(12'h03C, rd);
        chk("R6", "raw after clear", rd, 32'h0);

        // R5: receive pulse sets bit 4
        @(negedge clk); rx_set = 1'b1;
        @(negedge clk); rx_set = 1'b0;
        apb_rd(12'h03C, rd);
        chk("R5", "raw after rx_set", rd, 32'h10);
        chk("R8", "rx not enabled", {31'b0, irq}, 32'h0);
        apb_wr(12'h038, 32'hFFFF_FF30, 1'b0);
        chk("R8", "irq rx enabled", {31'b0, irq}, 32'h1);
        apb_rd(12'h040, rd);
        chk("R7", "masked rx", rd, 32'h10);

        // R5: set beats a same-cycle clear
        apb_wr(12'h044, 32'h0000_0010, 1'b1);
        apb_rd(12'h03C, rd);
        chk("R5", "set wins over clear", rd, 32'h10);
        apb_wr(12'h044, 32'h0000_0010, 1'b0);
        apb_rd(12'h03C, rd);
        chk("R6", "rx cleared", rd, 32'h0);
        chk("R8", "irq low after rx clear", {31'b0, irq}, 32'h0);

        // R6: clear bits outside 5 leave the transmit bit alone
        apb_wr(12'h000, 32'h0000_0042, 1'b0);
        apb_wr(12'h044, 32'hFFFF_FFDF, 1'b0);
        apb_rd(12'h03C, rd);
        chk("R6", "stray clear bits", rd, 32'h20);
        chk("R8", "irq tx pending", {31'b0, irq}, 32'h1);
        apb_wr(12'h038, 32'h0, 1'b0);
        chk("R8", "irq after mask off", {31'b0, irq}, 32'h0);

        // R4: data read returns rx_data and pops
        rx_data = 8'h5A;
        apb_rd(12'h000, rd);
        chk("R4", "data read", rd, 32'h5A);
        chk("R4", "rx_pop on data read", {31'b0, pop_seen}, 32'h1);
        apb_rd(12'h018, rd);
        chk("R4", "no pop on other read", {31'b0, pop_seen}, 32'h0);

        // R9: flags follow stat_in
        @(negedge clk); stat_in = 4'b0110;
        apb_rd(12'h018, rd);
        chk("R9", "flags track status", rd, 32'h60);

        done = 1'b1;
        finish_run();
    end

endmodule